// File: doc/BRIEF.md
# Chained Prioritizing Interrupt Controller

This block watches a vector of interrupt request lines and, for the most urgent enabled line, presents to the processor the handler address, the 6-bit interrupt level, the shadow register set index and the nonmaskable flag that software has configured for that line. Each line's configuration is loaded through a simple write port that sets all of the line's fields at once.

The block has an upstream input that carries the same four fields plus a valid bit from another controller of the same kind. It forwards either its own best candidate or the upstream one, whichever is more urgent. The controllers can therefore be chained to any depth, and the controller nearest the processor presents the most urgent request in the whole chain. Every stage registers its output, so each stage adds one cycle and no combinational path crosses stage boundaries.

The presented request is a level-held qualifier and has no ready input. The output stays valid for as long as the winning source keeps its request asserted. The processor does not acknowledge through this block. It clears the request at the peripheral, and the output drops on the next cycle. Urgency is compared as the key {nmi, level}, and the larger key wins.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, and one cycle after no enabled local line is requesting while `up_valid` is low, `out_valid` is 0. Right after reset all output fields are 0.
- R2: On reset every line's configuration is cleared: the line is disabled, its level is 0, its register set is 0 and its nonmaskable flag is clear. A requesting line therefore produces no output until it is written.
- R3: A write with `cfg_we`=1 stores `cfg_en`, `cfg_nmi`, `cfg_level`, `cfg_rset` and `cfg_addr` for line `cfg_line` at the clock edge. When that line wins, the output carries exactly the stored fields. Several lines may hold the same register set index.
- R4: A line whose enable is 0 is ignored even when its request is high.
- R5: An enabled request whose nonmaskable flag is set beats any maskable request, whatever the levels.
- R6: Among requests with the same nonmaskable flag, the higher level wins.
- R7: Among local lines with equal nonmaskable flag and level, the lowest line index wins.
- R8: The upstream candidate is forwarded only when its {nmi, level} key is strictly greater than that of the local winner. On an equal key the local winner is forwarded.
- R9: The output is registered. A request change applied before clock edge k shows on the outputs after edge k and not before it.
- R10: With no local request, a valid upstream request passes to the output unchanged, with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | NUM_LINES | Request lines, level sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_line | input | IDX_W | Line selected by the write |
| cfg_en | input | 1 | Enable for the selected line |
| cfg_nmi | input | 1 | Nonmaskable flag for the selected line |
| cfg_level | input | 6 | Interrupt level for the selected line |
| cfg_rset | input | RSET_W | Shadow register set for the selected line |
| cfg_addr | input | ADDR_W | Handler address for the selected line |
| up_valid | input | 1 | Upstream request present |
| up_nmi | input | 1 | Upstream nonmaskable flag |
| up_level | input | 6 | Upstream level |
| up_rset | input | RSET_W | Upstream register set |
| up_addr | input | ADDR_W | Upstream handler address |
| out_valid | output | 1 | Presented request is valid |
| out_nmi | output | 1 | Presented nonmaskable flag |
| out_level | output | 6 | Presented level |
| out_rset | output | RSET_W | Presented register set |
| out_addr | output | ADDR_W | Presented handler address |

## Verification
The bench builds the block with its defaults: eight lines, 32-bit addresses and a 3-bit register set index. Eight lines are enough to place a disabled line with the top level, a nonmaskable line with a low level, and two maskable lines that tie on level, all in the same request vector. The upstream port is driven directly as a stand-in for a neighbouring stage. This reaches the merge rules for strictly-greater keys, equal keys and nonmaskable against maskable, as well as the one-cycle latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 6;

  // true when candidate a is strictly more urgent than candidate b
  function automatic logic more_urgent(input logic a_nmi, input logic [LVL_W-1:0] a_lvl,
                                       input logic b_nmi, input logic [LVL_W-1:0] b_lvl);
    return {a_nmi, a_lvl} > {b_nmi, b_lvl};
  endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 32,
  parameter int RSET_W    = 3,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_line,
  input  logic              cfg_en,
  input  logic              cfg_nmi,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic [RSET_W-1:0] cfg_rset,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              en_q   [NUM_LINES],
  output logic              nmi_q  [NUM_LINES],
  output logic [LVL_W-1:0]  lvl_q  [NUM_LINES],
  output logic [RSET_W-1:0] rset_q [NUM_LINES],
  output logic [ADDR_W-1:0] addr_q [NUM_LINES]
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit;
    assign hit = cfg_we && (cfg_line == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]   <= 1'b0;
        nmi_q[g]  <= 1'b0;
        lvl_q[g]  <= '0;
        rset_q[g] <= '0;
        addr_q[g] <= '0;
      end else if (hit) begin
        en_q[g]   <= cfg_en;
        nmi_q[g]  <= cfg_nmi;
        lvl_q[g]  <= cfg_level;
        rset_q[g] <= cfg_rset;
        addr_q[g] <= cfg_addr;
      end
    end
  end

  // R3
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (lvl_q[$past(cfg_line)] == $past(cfg_level)) &&
               (addr_q[$past(cfg_line)] == $past(cfg_addr)) &&
               (en_q[$past(cfg_line)] == $past(cfg_en)));

endmodule

// File: rtl/irqc_local_pick.sv
module irqc_local_pick
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 32,
  parameter int RSET_W    = 3,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LINES-1:0] irq,
  input  logic              en_q   [NUM_LINES],
  input  logic              nmi_q  [NUM_LINES],
  input  logic [LVL_W-1:0]  lvl_q  [NUM_LINES],
  input  logic [RSET_W-1:0] rset_q [NUM_LINES],
  input  logic [ADDR_W-1:0] addr_q [NUM_LINES],
  output logic              loc_valid,
  output logic              loc_nmi,
  output logic [LVL_W-1:0]  loc_level,
  output logic [RSET_W-1:0] loc_rset,
  output logic [ADDR_W-1:0] loc_addr
);

  logic [NUM_LINES-1:0] active;
  logic [IDX_W-1:0]     win_idx;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_act
    assign active[g] = irq[g] && en_q[g];
  end

  // ascending scan with strict compare: lowest index keeps a tie
  always_comb begin
    loc_valid = 1'b0;
    win_idx   = '0;
    loc_nmi   = 1'b0;
    loc_level = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (active[i] && (!loc_valid || more_urgent(nmi_q[i], lvl_q[i], loc_nmi, loc_level))) begin
        loc_valid = 1'b1;
        win_idx   = IDX_W'(i);
        loc_nmi   = nmi_q[i];
        loc_level = lvl_q[i];
      end
    end
  end

  assign loc_rset = rset_q[win_idx];
  assign loc_addr = addr_q[win_idx];

  // R4
  winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> (en_q[win_idx] && irq[win_idx]));

endmodule

// File: rtl/irqc_chain_merge.sv
module irqc_chain_merge
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RSET_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_valid,
  input  logic              loc_nmi,
  input  logic [LVL_W-1:0]  loc_level,
  input  logic [RSET_W-1:0] loc_rset,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              up_valid,
  input  logic              up_nmi,
  input  logic [LVL_W-1:0]  up_level,
  input  logic [RSET_W-1:0] up_rset,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              out_valid,
  output logic              out_nmi,
  output logic [LVL_W-1:0]  out_level,
  output logic [RSET_W-1:0] out_rset,
  output logic [ADDR_W-1:0] out_addr
);

  logic take_up;
  assign take_up = up_valid &&
                   (!loc_valid || more_urgent(up_nmi, up_level, loc_nmi, loc_level));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_nmi   <= 1'b0;
      out_level <= '0;
      out_rset  <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= loc_valid || up_valid;
      if (take_up) begin
        out_nmi   <= up_nmi;
        out_level <= up_level;
        out_rset  <= up_rset;
        out_addr  <= up_addr;
      end else begin
        out_nmi   <= loc_nmi;
        out_level <= loc_level;
        out_rset  <= loc_rset;
        out_addr  <= loc_addr;
      end
    end
  end

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_valid && !up_valid) |=> !out_valid);

  // R5
  up_nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_nmi && !(loc_valid && loc_nmi)) |=> (out_valid && out_nmi));

  // R8
  local_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && up_valid && up_nmi == loc_nmi && up_level == loc_level)
      |=> (out_addr == $past(loc_addr)));

  // R10
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !loc_valid) |=> (out_valid && out_addr == $past(up_addr) &&
                                  out_rset == $past(up_rset)));

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 32,
  parameter int RSET_W    = 3,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_line,
  input  logic                 cfg_en,
  input  logic                 cfg_nmi,
  input  logic [LVL_W-1:0]     cfg_level,
  input  logic [RSET_W-1:0]    cfg_rset,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic                 up_valid,
  input  logic                 up_nmi,
  input  logic [LVL_W-1:0]     up_level,
  input  logic [RSET_W-1:0]    up_rset,
  input  logic [ADDR_W-1:0]    up_addr,
  output logic                 out_valid,
  output logic                 out_nmi,
  output logic [LVL_W-1:0]     out_level,
  output logic [RSET_W-1:0]    out_rset,
  output logic [ADDR_W-1:0]    out_addr
);

  logic              en_q   [NUM_LINES];
  logic              nmi_q  [NUM_LINES];
  logic [LVL_W-1:0]  lvl_q  [NUM_LINES];
  logic [RSET_W-1:0] rset_q [NUM_LINES];
  logic [ADDR_W-1:0] addr_q [NUM_LINES];

  logic              loc_valid;
  logic              loc_nmi;
  logic [LVL_W-1:0]  loc_level;
  logic [RSET_W-1:0] loc_rset;
  logic [ADDR_W-1:0] loc_addr;

  irqc_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .RSET_W(RSET_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_en(cfg_en), .cfg_nmi(cfg_nmi),
    .cfg_level(cfg_level), .cfg_rset(cfg_rset), .cfg_addr(cfg_addr),
    .en_q(en_q), .nmi_q(nmi_q), .lvl_q(lvl_q), .rset_q(rset_q), .addr_q(addr_q)
  );

  irqc_local_pick #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .RSET_W(RSET_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .en_q(en_q), .nmi_q(nmi_q), .lvl_q(lvl_q), .rset_q(rset_q), .addr_q(addr_q),
    .loc_valid(loc_valid), .loc_nmi(loc_nmi), .loc_level(loc_level),
    .loc_rset(loc_rset), .loc_addr(loc_addr)
  );

  irqc_chain_merge #(.ADDR_W(ADDR_W), .RSET_W(RSET_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .loc_valid(loc_valid), .loc_nmi(loc_nmi), .loc_level(loc_level),
    .loc_rset(loc_rset), .loc_addr(loc_addr),
    .up_valid(up_valid), .up_nmi(up_nmi), .up_level(up_level),
    .up_rset(up_rset), .up_addr(up_addr),
    .out_valid(out_valid), .out_nmi(out_nmi), .out_level(out_level),
    .out_rset(out_rset), .out_addr(out_addr)
  );

endmodule

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_line = '0;
  logic        cfg_en = 1'b0, cfg_nmi = 1'b0;
  logic [5:0]  cfg_level = '0;
  logic [2:0]  cfg_rset = '0;
  logic [31:0] cfg_addr = '0;
  logic        up_valid = 1'b0, up_nmi = 1'b0;
  logic [5:0]  up_level = '0;
  logic [2:0]  up_rset = '0;
  logic [31:0] up_addr = '0;
  logic        out_valid, out_nmi;
  logic [5:0]  out_level;
  logic [2:0]  out_rset;
  logic [31:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_chain_ctrl u_irq_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_en(cfg_en), .cfg_nmi(cfg_nmi),
    .cfg_level(cfg_level), .cfg_rset(cfg_rset), .cfg_addr(cfg_addr),
    .up_valid(up_valid), .up_nmi(up_nmi), .up_level(up_level),
    .up_rset(up_rset), .up_addr(up_addr),
    .out_valid(out_valid), .out_nmi(out_nmi), .out_level(out_level),
    .out_rset(out_rset), .out_addr(out_addr)
  );

  function automatic logic [42:0] pk(logic v, logic n, logic [5:0] l, logic [2:0] r, logic [31:0] a);
    return {v, n, l, r, a};
  endfunction

  function automatic logic [31:0] haddr(int i);
    return 32'h0000_1000 + 32'(i * 16);
  endfunction

  task automatic chk(string tag, logic [42:0] exp);
    logic [42:0] act;
    act = {out_valid, out_nmi, out_level, out_rset, out_addr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_valid(string tag, logic exp);
    n_chk++;
    if (out_valid !== exp) begin
      n_bad++;
      $display("FAIL %s valid actual=%b expected=%b", tag, out_valid, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample at next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int line, logic en, logic nmi, logic [5:0] lvl, logic [2:0] rs);
    cfg_we = 1'b1; cfg_line = 3'(line); cfg_en = en; cfg_nmi = nmi;
    cfg_level = lvl; cfg_rset = rs; cfg_addr = haddr(line);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_up(logic v, logic n, logic [5:0] l, logic [2:0] r, logic [31:0] a);
    up_valid = v; up_nmi = n; up_level = l; up_rset = r; up_addr = a;
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", pk(0, 0, 0, 0, 0));
    irq = 8'hFF;
    step();
    chk_valid("R2 unconfigured lines give no request", 1'b0);
    irq = 8'h00;
    set_up(1, 0, 6'd7, 3'd6, 32'hCAFE_0000);
    step();
    chk("R10 upstream passthrough", pk(1, 0, 6'd7, 3'd6, 32'hCAFE_0000));
    set_up(0, 0, 0, 0, 0);
    step();
    chk_valid("R1 idle after upstream drops", 1'b0);
  endtask

  task automatic t_config();
    wr(2, 1, 0, 6'd5, 3'd1);
    wr(3, 1, 1, 6'd1, 3'd3);
    wr(5, 1, 0, 6'd9, 3'd1);
    wr(6, 1, 0, 6'd9, 3'd2);
    wr(7, 0, 0, 6'd63, 3'd4);
    irq = 8'b0000_0100;
    step();
    chk("R3 single line fields", pk(1, 0, 6'd5, 3'd1, haddr(2)));
  endtask

  task automatic t_level();
    irq = 8'b0010_0100;
    step();
    chk("R6 higher level wins", pk(1, 0, 6'd9, 3'd1, haddr(5)));
  endtask

  task automatic t_tie();
    irq = 8'b0110_0000;
    step();
    chk("R7 tie to lower index", pk(1, 0, 6'd9, 3'd1, haddr(5)));
    irq = 8'b0100_0000;
    step();
    chk("R3 line 6 fields", pk(1, 0, 6'd9, 3'd2, haddr(6)));
  endtask

  task automatic t_disabled();
    irq = 8'b1000_0100;
    step();
    chk("R4 disabled line ignored", pk(1, 0, 6'd5, 3'd1, haddr(2)));
    irq = 8'b1000_0000;
    step();
    chk_valid("R4 disabled line alone", 1'b0);
  endtask

  task automatic t_nmi();
    irq = 8'b0110_1000;
    step();
    chk("R5 nmi beats higher level", pk(1, 1, 6'd1, 3'd3, haddr(3)));
  endtask

  task automatic t_merge();
    irq = 8'b0010_0000;
    set_up(1, 0, 6'd10, 3'd5, 32'hDEAD_0000);
    step();
    chk("R8 upstream higher level", pk(1, 0, 6'd10, 3'd5, 32'hDEAD_0000));
    set_up(1, 0, 6'd9, 3'd5, 32'hDEAD_0000);
    step();
    chk("R8 equal key keeps local", pk(1, 0, 6'd9, 3'd1, haddr(5)));
    set_up(1, 1, 6'd0, 3'd7, 32'hBEEF_0000);
    step();
    chk("R5 upstream nmi beats local", pk(1, 1, 6'd0, 3'd7, 32'hBEEF_0000));
    irq = 8'b0000_1000;
    step();
    chk("R8 local nmi higher level", pk(1, 1, 6'd1, 3'd3, haddr(3)));
    set_up(0, 0, 0, 0, 0);
    irq = 8'h00;
    step();
  endtask

  task automatic t_latency();
    irq = 8'b0000_0100;
    #1;
    chk_valid("R9 no change before edge", 1'b0);
    step();
    chk("R9 change after one edge", pk(1, 0, 6'd5, 3'd1, haddr(2)));
    irq = 8'h00;
    #1;
    chk_valid("R9 held before edge", 1'b1);
    step();
    chk_valid("R1 drop after release", 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_level();
    t_tie();
    t_disabled();
    t_nmi();
    t_merge();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule